// File: doc/BRIEF.md
# ADC Autoranging Gain Controller

This block drives the gain select of a programmable-gain amplifier in front of a 12-bit ADC. The aim is to use as much of the converter's range as possible. A measurement begins at the lowest gain and runs a conversion. When the top bit of the converted word is clear, the gain is doubled, the amplifier is given time to settle, and the conversion runs again. The search ends at the first word whose top bit is set, or at the gain ceiling.

The gain select is a 3-bit exponent: code k selects a gain of 2^k, from 1 up to 16. The converter handshake has three signals: a one-cycle start pulse, a busy level from the converter, and its data word. Each finished measurement produces a one-cycle valid pulse together with the accepted word and the exponent it was taken at. The settling wait is set by a count input, in clock cycles.

Top module: `adc_autorange_ctrl`

## Requirements
- R1: While rst_ni is low, gain_o is 0 and adc_start_o and res_valid_o are both 0.
- R2: A start_i sampled high while idle sets gain_o to 0, and the first conversion of the measurement runs at gain code 0.
- R3: After every gain load (initial or step), adc_start_o rises exactly settle_cycles_i+1 clock cycles after the edge that loaded the gain.
- R4: adc_start_o is a one-cycle pulse. The conversion completes on the first rising edge after the one ending the pulse at which adc_busy_i is low, and adc_data_i is taken at that edge.
- R5: If bit 11 of the word is 0 and gain_o is below 4, gain_o increments by one and a new conversion follows, so a measurement uses exactly (final exponent + 1) conversions.
- R6: A word with bit 11 set is accepted at the current gain.
- R7: At gain code 4 the word is accepted whatever its bit 11.
- R8: On acceptance, res_valid_o pulses for one cycle with res_data_o and res_gain_o holding the word and exponent; these hold until the next acceptance.
- R9: start_i while a measurement is in progress is ignored: the measurement and its result are unaffected and no extra result appears.
- R10: start_i high in the cycle res_valid_o is high starts a new measurement.
- R11: gain_o keeps the final exponent after a measurement until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Measurement request |
| settle_cycles_i | input | 8 | Settling wait after each gain load, in cycles |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_busy_i | input | 1 | Converter busy level |
| adc_data_i | input | 12 | Converter result word |
| gain_o | output | 3 | Amplifier gain exponent |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Accepted word |
| res_gain_o | output | 3 | Exponent of accepted word |

## Verification
Two events can fall in the same cycle: the result strobe of one measurement and the acceptance of the next start request. The bench forces this by raising start_i just after the edge that raises res_valid_o. It then judges that the old result is reported intact, that the new measurement begins at gain 0 with the correct settling delay, and that it ends with its own result. A start raised during a hunt is judged by the result exponent and by the result count.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CONV,
    ST_WAIT
  } ar_state_e;
endpackage

// File: rtl/ar_settle_timer.sv
module ar_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ar_gain_ctrl.sv
module ar_gain_ctrl #(
  parameter int GAIN_W   = 3,
  parameter int MAX_GAIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              at_max_o
);
  localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(MAX_GAIN);

  logic [GAIN_W-1:0] gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gain_q <= '0;
    else if (clear_i)                gain_q <= '0;
    else if (step_i && !at_max_o)    gain_q <= gain_q + 1'b1;
  end

  assign at_max_o = (gain_q >= GMAX);
  assign gain_o   = gain_q;
endmodule

// File: rtl/ar_seq.sv
module ar_seq
  import ar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic expired_i,
  input  logic busy_i,
  input  logic msb_i,
  input  logic at_max_i,
  output logic timer_load_o,
  output logic gain_clear_o,
  output logic gain_step_o,
  output logic adc_start_o,
  output logic capture_o
);
  ar_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d      = state_q;
    timer_load_o = 1'b0;
    gain_clear_o = 1'b0;
    gain_step_o  = 1'b0;
    capture_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        gain_clear_o = 1'b1;
        timer_load_o = 1'b1;
        state_d      = ST_SETTLE;
      end
      ST_SETTLE: if (expired_i) state_d = ST_CONV;
      ST_CONV:   state_d = ST_WAIT;
      ST_WAIT: if (!busy_i) begin
        if (!msb_i && !at_max_i) begin
          // top bit clear and headroom left: double gain and retry
          gain_step_o  = 1'b1;
          timer_load_o = 1'b1;
          state_d      = ST_SETTLE;
        end else begin
          capture_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign adc_start_o = (state_q == ST_CONV);
endmodule

// File: rtl/adc_autorange_ctrl.sv
module adc_autorange_ctrl #(
  parameter int DATA_W   = 12,
  parameter int GAIN_W   = 3,
  parameter int MAX_GAIN = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic                adc_start_o,
  input  logic                adc_busy_i,
  input  logic [DATA_W-1:0]   adc_data_i,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                res_valid_o,
  output logic [DATA_W-1:0]   res_data_o,
  output logic [GAIN_W-1:0]   res_gain_o
);
  localparam int MSB = DATA_W - 1;

  logic timer_load, expired, gain_clear, gain_step, at_max, capture;
  logic [GAIN_W-1:0] gain;

  ar_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (timer_load),
    .load_val_i (settle_cycles_i),
    .expired_o  (expired)
  );

  ar_gain_ctrl #(.GAIN_W(GAIN_W), .MAX_GAIN(MAX_GAIN)) u_gain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (gain_clear),
    .step_i   (gain_step),
    .gain_o   (gain),
    .at_max_o (at_max)
  );

  ar_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .expired_i    (expired),
    .busy_i       (adc_busy_i),
    .msb_i        (adc_data_i[MSB]),
    .at_max_i     (at_max),
    .timer_load_o (timer_load),
    .gain_clear_o (gain_clear),
    .gain_step_o  (gain_step),
    .adc_start_o  (adc_start_o),
    .capture_o    (capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_gain_o  <= '0;
    end else begin
      res_valid_o <= capture;
      if (capture) begin
        res_data_o <= adc_data_i;
        res_gain_o <= gain;
      end
    end
  end

  assign gain_o = gain;
endmodule

// File: rtl/ar_checker.sv
module ar_checker #(
  parameter int DATA_W   = 12,
  parameter int GAIN_W   = 3,
  parameter int MAX_GAIN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_start_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic [GAIN_W-1:0] res_gain_o
);
  a_r7_gain_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= GAIN_W'(MAX_GAIN));

  a_r5_gain_step_or_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_o) |-> (gain_o == GAIN_W'($past(gain_o) + 1'b1)) || (gain_o == '0));

  a_r3_no_start_on_gain_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_o) |-> !adc_start_o);

  a_r4_start_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  a_r8_valid_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r6_msb_set_below_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_gain_o != GAIN_W'(MAX_GAIN)) |-> res_data_o[DATA_W-1]);

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> ($stable(res_data_o) && $stable(res_gain_o)));
endmodule

bind adc_autorange_ctrl ar_checker #(
  .DATA_W(DATA_W), .GAIN_W(GAIN_W), .MAX_GAIN(MAX_GAIN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adc_start_o (adc_start_o),
  .gain_o      (gain_o),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .res_gain_o  (res_gain_o)
);

// File: tb/adc_autorange_ctrl_test.sv
module adc_autorange_ctrl_test;
  localparam int DW = 12, GW = 3, MAXG = 4, SW = 8;

  logic clk = 0, rst_n = 0, start = 0, busy = 0;
  logic [SW-1:0] settle = '0;
  logic [DW-1:0] adata = '0;
  logic adc_start_o, res_valid_o;
  logic [GW-1:0] gain_o, res_gain_o;
  logic [DW-1:0] res_data_o;

  adc_autorange_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_cycles_i(settle),
    .adc_start_o(adc_start_o), .adc_busy_i(busy), .adc_data_i(adata),
    .gain_o(gain_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_gain_o(res_gain_o)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int amp_in = 0, cur_amp = 0, cyc = 0, t_load = 0, conv_seen = 0, results = 0;
  bit active = 0, done = 0;
  logic [GW-1:0] prev_gain = '0;

  function automatic int word_of(int a, int g);
    int w = a << g;
    return (w > 4095) ? 4095 : w;
  endfunction

  function automatic int exp_gain(int a);
    for (int g = 0; g < MAXG; g++)
      if (word_of(a, g) >= 2048) return g;
    return MAXG;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      if (res_valid_o) begin
        int eg;
        eg = exp_gain(cur_amp);
        if (eg == MAXG) chk(res_gain_o == GW'(eg), "R7 gain", res_gain_o, eg);
        else            chk(res_gain_o == GW'(eg), "R6 gain", res_gain_o, eg);
        chk(res_data_o == DW'(word_of(cur_amp, eg)), "R8 data", res_data_o, word_of(cur_amp, eg));
        chk(conv_seen == eg + 1, "R5 conversions", conv_seen, eg + 1);
        active = 0;
        results++;
      end
      if (gain_o != prev_gain) t_load = cyc;
      prev_gain = gain_o;
      if (adc_start_o) begin
        chk(cyc - t_load == int'(settle) + 1, "R3 settle", cyc - t_load, int'(settle) + 1);
        if (conv_seen == 0) chk(gain_o == '0, "R2 first gain", gain_o, 0);
        conv_seen++;
      end
      if (start && !active) begin
        active = 1;
        cur_amp = amp_in;
        t_load = cyc + 1;
        conv_seen = 0;
      end
    end
  end

  // converter and amplifier model
  initial forever begin
    @(negedge clk);
    if (adc_start_o) begin
      int lat;
      busy = 1;
      adata = DW'($urandom);
      @(negedge clk);
      chk(!adc_start_o, "R4 pulse", adc_start_o, 0);
      lat = $urandom_range(0, 3);
      repeat (lat) begin
        adata = DW'($urandom);
        @(negedge clk);
      end
      adata = DW'(word_of(cur_amp, gain_o));
      busy = 0;
    end
  end

  task automatic wait_res();
    do begin @(posedge clk); #1; end while (!res_valid_o);
  endtask

  task automatic hold_chk(int a);
    repeat (4) @(posedge clk);
    #1;
    chk(gain_o == GW'(exp_gain(a)), "R11 gain hold", gain_o, exp_gain(a));
    chk(!res_valid_o && res_data_o == DW'(word_of(a, exp_gain(a))), "R8 hold",
        res_data_o, word_of(a, exp_gain(a)));
  endtask

  task automatic run(int a, int s);
    @(posedge clk); #1;
    settle = SW'(s); amp_in = a; start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_res();
    hold_chk(a);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk(gain_o == '0 && !adc_start_o && !res_valid_o, "R1 reset", {adc_start_o, res_valid_o, gain_o}, 0);
    rst_n = 1;

    run(0, 0);       // R7: nothing ever sets the top bit
    run(2048, 3);    // R6 at gain 0
    run(1, 1);
    run(128, 2);     // R7 ceiling word with top bit set
    run(127, 0);
    run(1024, 5);
    run(4095, 2);

    // R9: request during a hunt is dropped
    @(posedge clk); #1;
    settle = 8'd4; amp_in = 300; start = 1;
    @(posedge clk); #1;
    start = 0;
    r0 = results;
    repeat (7) @(posedge clk);
    #1;
    amp_in = 3000; start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_res();
    chk(res_gain_o == GW'(exp_gain(300)), "R9 result", res_gain_o, exp_gain(300));
    repeat (20) @(posedge clk);
    #1;
    chk(results == r0 + 1, "R9 count", results - r0, 1);
    chk(!active, "R9 idle", active, 0);

    // R10: new request in the strobe cycle
    @(posedge clk); #1;
    settle = 8'd2; amp_in = 64; start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_res();
    r0 = results;
    amp_in = 2500; start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_res();
    chk(res_gain_o == '0 && res_data_o == DW'(2500), "R10 back-to-back", res_data_o, 2500);
    @(posedge clk); #1;
    chk(results == r0 + 2, "R10 count", results - r0, 2);

    for (int i = 0; i < 40; i++) begin
      int a;
      a = $urandom_range(0, 4095) >> $urandom_range(0, 12);
      run(a, $urandom_range(0, 20));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule